// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects every exception request that can reach the CPU and decides which one is serviced next. It covers three reset causes, an illegal-opcode trap, a software interrupt, one request that has its own mask bit (the X level), and a parameterised bank of ordinary requests that share the I mask bit. It signals the CPU combinationally that something is pending. When the CPU acknowledges a vector fetch, the block registers the 16-bit vector address of the winning request and raises a one-cycle valid strobe.

A small write port gives access to three registers. The first is a promotion register that lifts one ordinary source above all the others. The other two are test registers: in special mode they force ordinary requests or the X request so that the selection logic can be exercised. The block also drives a wake output for stop and wait. It wakes on any unmasked pending request, and on an active X request even while the X mask is set.

Top module: `ivc_top`

## Requirements
- R1: Ordinary source k (0 to NUM_I-1) uses vector 0xFFF2 - 2*k. Unmasked ordinary sources are taken only while iMask is 0. Among them, the higher vector address (lower k) wins.
- R2: The X request uses vector 0xFFF4. It is taken only while xMask is 0, and it beats every ordinary source, including the promoted one.
- R3: The trap (0xFFF8) and the software interrupt (0xFFF6) ignore both mask bits. The trap beats the software interrupt, and both beat the X request.
- R4: The reset causes use power-on 0xFFFE, clock monitor 0xFFFC and watchdog 0xFFFA, in that order of precedence. All three are above every other request.
- R5: A write with wrAddr=0 stores wrData in the promotion register, which resets to 0xF2. A pending, unmasked ordinary source whose vector low byte equals the register beats the other ordinary sources.
- R6: A promotion write with an odd value or a value above 0xF2 is ignored, and the previous promotion stays in force.
- R7: vecAddr and vecValid change only on the clock edge after a cycle with vecAck high. vecValid is high for that one cycle only if a request was pending. If nothing was pending, vecAddr keeps its value. After reset, vecAddr is 0xFFFE and vecValid is 0.
- R8: intPending is high in the same cycle as any reset cause, the trap, the software interrupt, an unmasked X request or an unmasked ordinary request.
- R9: wake equals lowPower AND (intPending OR an active X request). The X request counts for wake regardless of xMask.
- R10: Test forcing works only while specialMode is 1. A write with wrAddr=1 sets force bit wrData[6:0] to the value of wrData[7]. A write with wrAddr=2 sets the X force to wrData[0]. Forced requests count as requests only while specialMode is 1. Test writes made outside special mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irqReq | input | NUM_I | Ordinary request lines, bit k is source k |
| iMask | input | 1 | Mask for ordinary requests |
| xReq | input | 1 | X-level request |
| xMask | input | 1 | Mask for the X request |
| swiReq | input | 1 | Software interrupt / debug request |
| trapReq | input | 1 | Illegal-opcode trap |
| porReq | input | 1 | Power-on / external reset cause |
| cmReq | input | 1 | Clock monitor reset cause |
| copReq | input | 1 | Watchdog reset cause |
| lowPower | input | 1 | CPU is in stop or wait |
| specialMode | input | 1 | Special (test) mode enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 promotion, 1 force ordinary, 2 force X |
| wrData | input | 8 | Write data |
| vecAck | input | 1 | CPU vector-fetch acknowledge |
| intPending | output | 1 | A serviceable request exists |
| vecAddr | output | 16 | Registered vector address |
| vecValid | output | 1 | One-cycle strobe for a freshly captured vector |
| wake | output | 1 | Wake request for stop/wait |

## Verification
The assertions assume that the request and mask inputs are synchronous to clk and that vecAck is a level sampled on the clock edge. They also assume that all inputs hold known values once reset is released. The bench respects this by changing every input only on the falling edge. Each acknowledge it gives is a single-cycle pulse sent after the request pattern has settled, and it checks results on the next falling edge. No input changes while an acknowledge is being sampled.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [15:0] VEC_POR  = 16'hFFFE;
  localparam logic [15:0] VEC_CM   = 16'hFFFC;
  localparam logic [15:0] VEC_COP  = 16'hFFFA;
  localparam logic [15:0] VEC_TRAP = 16'hFFF8;
  localparam logic [15:0] VEC_SWI  = 16'hFFF6;
  localparam logic [15:0] VEC_X    = 16'hFFF4;
  localparam logic [15:0] VEC_ITOP = 16'hFFF2;
  localparam logic [7:0]  PRIO_RST = 8'hF2;

  localparam logic [1:0] ADDR_PRIO   = 2'd0;
  localparam logic [1:0] ADDR_FORCEI = 2'd1;
  localparam logic [1:0] ADDR_FORCEX = 2'd2;

  typedef struct packed {
    logic capture;
    logic forceEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             specialMode,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic             vecAck,
  output ctrlStrobes_t     strobes,
  output logic [7:0]       prioLow,
  output logic [NUM_I-1:0] forceI,
  output logic             forceX
);
  logic prioOk;
  logic testWr;

  assign prioOk = (wrData[0] == 1'b0) && (wrData <= PRIO_RST);
  assign testWr = wrEn && specialMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prioLow <= PRIO_RST;
    end else if (wrEn && wrAddr == ADDR_PRIO && prioOk) begin
      prioLow <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forceI <= '0;
      forceX <= 1'b0;
    end else if (testWr) begin
      if (wrAddr == ADDR_FORCEI) begin
        for (int k = 0; k < NUM_I; k++) begin
          if (wrData[6:0] == 7'(k)) forceI[k] <= wrData[7];
        end
      end
      if (wrAddr == ADDR_FORCEX) forceX <= wrData[0];
    end
  end

  always_comb begin
    strobes.capture = vecAck;
    strobes.forceEn = specialMode;
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [7:0]       prioLow,
  input  logic [NUM_I-1:0] forceI,
  input  logic             forceX,
  input  logic [NUM_I-1:0] irqReq,
  input  logic             iMask,
  input  logic             xReq,
  input  logic             xMask,
  input  logic             swiReq,
  input  logic             trapReq,
  input  logic             porReq,
  input  logic             cmReq,
  input  logic             copReq,
  input  logic             lowPower,
  output logic             intPending,
  output logic [15:0]      vecAddr,
  output logic             vecValid,
  output logic             wake
);
  logic [NUM_I-1:0] iAct;
  logic             xRaw;
  logic             xAct;
  logic [7:0]       promOff;
  logic [6:0]       promIdx;
  logic             promHit;
  logic [15:0]      promVec;
  logic             plainHit;
  logic [15:0]      plainVec;
  logic [15:0]      selVec;
  logic             anyPend;

  assign iAct    = (irqReq | (forceI & {NUM_I{strobes.forceEn}})) & {NUM_I{~iMask}};
  assign xRaw    = xReq | (forceX & strobes.forceEn);
  assign xAct    = xRaw & ~xMask;
  assign promOff = PRIO_RST - prioLow;
  assign promIdx = promOff[7:1];

  always_comb begin
    promHit = 1'b0;
    promVec = VEC_ITOP;
    for (int k = 0; k < NUM_I; k++) begin
      if (promIdx == 7'(k) && iAct[k]) begin
        promHit = 1'b1;
        promVec = VEC_ITOP - 16'(2 * k);
      end
    end
  end

  always_comb begin
    plainHit = 1'b0;
    plainVec = VEC_ITOP;
    for (int k = NUM_I - 1; k >= 0; k--) begin
      if (iAct[k]) begin
        plainHit = 1'b1;
        plainVec = VEC_ITOP - 16'(2 * k);
      end
    end
  end

  always_comb begin
    anyPend = 1'b1;
    if (porReq)        selVec = VEC_POR;
    else if (cmReq)    selVec = VEC_CM;
    else if (copReq)   selVec = VEC_COP;
    else if (trapReq)  selVec = VEC_TRAP;
    else if (swiReq)   selVec = VEC_SWI;
    else if (xAct)     selVec = VEC_X;
    else if (promHit)  selVec = promVec;
    else if (plainHit) selVec = plainVec;
    else begin
      selVec  = vecAddr;
      anyPend = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecAddr  <= VEC_POR;
      vecValid <= 1'b0;
    end else begin
      vecValid <= strobes.capture && anyPend;
      if (strobes.capture && anyPend) vecAddr <= selVec;
    end
  end

  assign intPending = anyPend;
  assign wake       = lowPower & (anyPend | xRaw);
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_I-1:0] irqReq,
  input  logic             iMask,
  input  logic             xReq,
  input  logic             xMask,
  input  logic             swiReq,
  input  logic             trapReq,
  input  logic             porReq,
  input  logic             cmReq,
  input  logic             copReq,
  input  logic             lowPower,
  input  logic             specialMode,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic             vecAck,
  output logic             intPending,
  output logic [15:0]      vecAddr,
  output logic             vecValid,
  output logic             wake
);
  ctrlStrobes_t     strobes;
  logic [7:0]       prioLow;
  logic [NUM_I-1:0] forceI;
  logic             forceX;

  ivc_ctrl #(.NUM_I(NUM_I)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .specialMode(specialMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .vecAck(vecAck),
    .strobes(strobes), .prioLow(prioLow), .forceI(forceI), .forceX(forceX)
  );

  ivc_datapath #(.NUM_I(NUM_I)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .prioLow(prioLow),
    .forceI(forceI), .forceX(forceX), .irqReq(irqReq), .iMask(iMask),
    .xReq(xReq), .xMask(xMask), .swiReq(swiReq), .trapReq(trapReq),
    .porReq(porReq), .cmReq(cmReq), .copReq(copReq), .lowPower(lowPower),
    .intPending(intPending), .vecAddr(vecAddr), .vecValid(vecValid), .wake(wake)
  );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vecAck,
  input logic        porReq,
  input logic        xReq,
  input logic        lowPower,
  input logic        wake,
  input logic [15:0] vecAddr,
  input logic        vecValid
);
  assert_valid_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(vecAck));

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vecAck) |-> $stable(vecAddr));

  assert_por_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vecAck && porReq) |=> (vecAddr == 16'hFFFE && vecValid));

  assert_no_wake_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lowPower |-> !wake);

  assert_x_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lowPower && xReq) |-> wake);

  assert_vec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> (vecAddr[15:8] == 8'hFF && !vecAddr[0]));
endmodule

bind ivc_top ivc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .vecAck(vecAck), .porReq(porReq),
  .xReq(xReq), .lowPower(lowPower), .wake(wake),
  .vecAddr(vecAddr), .vecValid(vecValid)
);

// File: tb/ivc_tb.sv
module ivc_top_tb_top;
  localparam int NUM_I = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_I-1:0] irqReq = '0;
  logic iMask = 1'b0, xReq = 1'b0, xMask = 1'b0, swiReq = 1'b0, trapReq = 1'b0;
  logic porReq = 1'b0, cmReq = 1'b0, copReq = 1'b0;
  logic lowPower = 1'b0, specialMode = 1'b0, wrEn = 1'b0, vecAck = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic intPending, vecValid, wake;
  logic [15:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  ivc_top #(.NUM_I(NUM_I)) dut_i (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .iMask(iMask), .xReq(xReq),
    .xMask(xMask), .swiReq(swiReq), .trapReq(trapReq), .porReq(porReq),
    .cmReq(cmReq), .copReq(copReq), .lowPower(lowPower),
    .specialMode(specialMode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vecAck(vecAck), .intPending(intPending), .vecAddr(vecAddr),
    .vecValid(vecValid), .wake(wake)
  );

  // ctl bits: {xReq, iMask, xMask, swiReq, trapReq, porReq, cmReq, copReq}
  typedef struct packed {
    logic [7:0]  irq;
    logic [7:0]  ctl;
    logic [15:0] expVec;
    logic        expPend;
  } row_t;

  localparam row_t TBL [12] = '{
    '{8'h01, 8'b00000000, 16'hFFF2, 1'b1},  // R1 top source
    '{8'h80, 8'b00000000, 16'hFFE4, 1'b1},  // R1 lowest source
    '{8'h84, 8'b00000000, 16'hFFEE, 1'b1},  // R1 higher address wins
    '{8'hFF, 8'b01000000, 16'hFFEE, 1'b0},  // R1 masked, R7 hold
    '{8'h01, 8'b10000000, 16'hFFF4, 1'b1},  // R2 X over I
    '{8'h02, 8'b10100000, 16'hFFF0, 1'b1},  // R2 X masked
    '{8'h00, 8'b10010000, 16'hFFF6, 1'b1},  // R3 SWI over X
    '{8'h00, 8'b00011000, 16'hFFF8, 1'b1},  // R3 trap over SWI
    '{8'h00, 8'b00001001, 16'hFFFA, 1'b1},  // R4 watchdog over trap
    '{8'h00, 8'b00000011, 16'hFFFC, 1'b1},  // R4 clock monitor over watchdog
    '{8'h00, 8'b00000110, 16'hFFFE, 1'b1},  // R4 power-on first
    '{8'h00, 8'b01110000, 16'hFFF6, 1'b1}   // R3 ignores masks
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    irqReq = '0; {xReq, iMask, xMask, swiReq, trapReq, porReq, cmReq, copReq} = '0;
  endtask

  task automatic ack();
    @(negedge clk) vecAck = 1'b1;
    @(negedge clk) vecAck = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrAddr = a; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset vecAddr", vecAddr, 16'hFFFE);
    chk("R7 reset vecValid", 16'(vecValid), 16'h0);
    chk("R8 reset pending", 16'(intPending), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (TBL[i]) begin
      @(negedge clk) begin
        irqReq = TBL[i].irq;
        {xReq, iMask, xMask, swiReq, trapReq, porReq, cmReq, copReq} = TBL[i].ctl;
      end
      #1 chk($sformatf("R8 row %0d pending", i), 16'(intPending), 16'(TBL[i].expPend));
      ack();
      chk($sformatf("R7 row %0d vector", i), vecAddr, TBL[i].expVec);
      chk($sformatf("R7 row %0d valid", i), 16'(vecValid), 16'(TBL[i].expPend));
    end
    clearIn();

    // R7 valid is a single cycle, vector stable without ack
    irqReq = 8'h01;
    ack();
    @(negedge clk);
    chk("R7 valid drops", 16'(vecValid), 16'h0);
    irqReq = 8'h80;
    repeat (2) @(negedge clk);
    chk("R7 vector stable without ack", vecAddr, 16'hFFF2);

    // R5 promotion
    wr(2'd0, 8'hEA);
    irqReq = 8'h11;
    ack();
    chk("R5 promoted source 4", vecAddr, 16'hFFEA);
    // R6 illegal writes ignored
    wr(2'd0, 8'hE5);
    ack();
    chk("R6 odd write ignored", vecAddr, 16'hFFEA);
    wr(2'd0, 8'hF4);
    irqReq = 8'h01;
    ack();
    chk("R6 above-range write ignored (source 0 alone)", vecAddr, 16'hFFF2);
    irqReq = 8'h11;
    ack();
    chk("R6 promotion kept", vecAddr, 16'hFFEA);
    wr(2'd0, 8'hE4);
    irqReq = 8'h81;
    ack();
    chk("R5 promoted lowest source", vecAddr, 16'hFFE4);
    xReq = 1'b1;
    ack();
    chk("R2 X beats promoted", vecAddr, 16'hFFF4);
    clearIn();

    // R9 wake
    @(negedge clk) begin lowPower = 1'b1; xReq = 1'b1; xMask = 1'b1; end
    #1 chk("R9 masked X wakes", 16'(wake), 16'h1);
    chk("R8 masked X not pending", 16'(intPending), 16'h0);
    @(negedge clk) begin xReq = 1'b0; xMask = 1'b0; irqReq = 8'h04; iMask = 1'b1; end
    #1 chk("R9 masked I no wake", 16'(wake), 16'h0);
    @(negedge clk) iMask = 1'b0;
    #1 chk("R9 unmasked I wakes", 16'(wake), 16'h1);
    @(negedge clk) lowPower = 1'b0;
    #1 chk("R9 no wake when running", 16'(wake), 16'h0);
    clearIn();

    // R10 test forcing
    wr(2'd1, 8'h83);
    specialMode = 1'b1;
    #1 chk("R10 force write outside special ignored", 16'(intPending), 16'h0);
    wr(2'd1, 8'h83);
    ack();
    chk("R10 forced source 3", vecAddr, 16'hFFEC);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h01);
    ack();
    chk("R10 forced X", vecAddr, 16'hFFF4);
    @(negedge clk) specialMode = 1'b0;
    #1 chk("R10 force inactive outside special", 16'(intPending), 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule